// File: doc/BRIEF.md
# LCD Multiplexed Frame Sequencer

This block generates the digital timing behind a segment LCD driver. From a slow source clock, a 2-bit multiplex select and a 4-bit prescaler field, it steps through the common phases of a frame. For each phase it raises a one-hot common indication and presents the row of pixel bits that belongs to that common, one bit per segment pin. Analog bias levels, drive polarity and clock source selection are handled elsewhere.

The pixel bits sit in a small store of one row per possible common. The host writes and reads this store through a simple row port. Rows or bits that the current mode does not display stay ordinary storage. A segment enable register chooses which pins are taken over by the segment driver. A taken-over pin has its direction setting overridden, and so does every common pin in use.

Each phase lasts K × (P+1) × TICK_DIV source clocks. P is the prescaler field and K is a mode-dependent multiplier: 4 for static, 2 for 1/2, and 1 for 1/3 and 1/4. A frame therefore lasts K × N × (P+1) × TICK_DIV clocks, where N is the number of commons. Mode and prescaler changes are picked up only at a frame boundary.

Top module: `lcd_frame_seq`

## Requirements
- R1: `mode_sel` selects the active commons. 00 gives static and `com_used`=0001. 01 gives 1/2 and `com_used`=0011. 10 gives 1/3 and `com_used`=0111. 11 gives 1/4 and `com_used`=1111. Bit i of `com_used` stands for common i.
- R2: While running, `com_act` is one-hot with bit i set during phase i. The phases go 0, 1, …, N−1 and then wrap to 0.
- R3: Each phase lasts exactly K × (P+1) × TICK_DIV clock cycles, with K = 4, 2, 1, 1 for modes 00, 01, 10, 11.
- R4: `phase_vld` is high for one cycle at the start of every phase. `frame_start` is high for one cycle, only together with the `phase_vld` of phase 0.
- R5: While a phase is active, `seg_row` equals the stored row of the active common, bitwise ANDed with the segment enable register.
- R6: All four pixel rows can be written and read back in any mode, including rows the mode does not display. `pix_rdata` shows row `pix_rcom` combinationally, and a write takes effect at the next clock edge.
- R7: After reset the segment enable register is all zero. `seg_drv_en` (direction override for segment pins) equals the register, which is written through `seg_en_we`.
- R8: `com_dir_ovr` equals `com_used`, so exactly the common pins in use override their direction setting.
- R9: A change to `mode_sel` or `presc_sel` during a frame does not alter the phase count, the `com_used` mask or the phase length until the next frame begins.
- R10: While `en` is low, `com_act`, `com_used`, `com_dir_ovr`, `seg_row`, `phase_vld` and `frame_start` are zero and the counters are held. The first cycle with `en` high starts phase 0 with `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Module enable; low holds counters in reset |
| mode_sel | input | 2 | Multiplex select |
| presc_sel | input | 4 | Prescaler field P (divide P+1) |
| pix_we | input | 1 | Pixel row write strobe |
| pix_wcom | input | 2 | Common index of row written |
| pix_wdata | input | NUM_SEG | Row write data |
| pix_rcom | input | 2 | Common index of row read |
| pix_rdata | output | NUM_SEG | Row read data |
| seg_en_we | input | 1 | Segment enable register write strobe |
| seg_en_wdata | input | NUM_SEG | Segment enable write data |
| com_act | output | 4 | One-hot active common |
| com_used | output | 4 | Commons in use for the latched mode |
| com_dir_ovr | output | 4 | Direction override for common pins |
| seg_row | output | NUM_SEG | Segment data for the active common |
| seg_drv_en | output | NUM_SEG | Pin taken by segment driver (direction override) |
| phase_vld | output | 1 | One-cycle strobe at each phase start |
| frame_start | output | 1 | One-cycle strobe at phase 0 start |

## Verification
The bench builds the block with NUM_SEG = 8 and TICK_DIV = 2. This shrinks the longest frame (mode 11, P = 15) to 128 cycles, so every mode can be paired with both the smallest and the largest prescaler and every resulting frame measured to the exact cycle. The short phases also make a mid-frame change of mode and prescaler quick to follow to the next boundary. Eight segments are enough to use a partial enable mask and distinct row patterns for each common.

// File: rtl/lcd_seq_pkg.sv
// Package: shared constants and decode helpers for the LCD frame sequencer.
// Assumes at most four commons and a 2-bit mode code.
package lcd_seq_pkg;

    localparam int NUM_COM = 4;

    typedef enum logic [1:0] {
        MUX_STATIC = 2'b00,
        MUX_HALF   = 2'b01,
        MUX_THIRD  = 2'b10,
        MUX_QUART  = 2'b11
    } mux_mode_e;

    // Number of commons driven in a mode, minus one.
    function automatic logic [1:0] last_com(input logic [1:0] mode);
        return mode;
    endfunction

    // Per-phase multiplier applied on top of the prescaler.
    function automatic logic [2:0] phase_mult(input logic [1:0] mode);
        case (mode)
            MUX_STATIC: return 3'd4;
            MUX_HALF:   return 3'd2;
            default:    return 3'd1;
        endcase
    endfunction

    // Mask of commons in use for a mode.
    function automatic logic [NUM_COM-1:0] used_mask(input logic [1:0] mode);
        case (mode)
            MUX_STATIC: return 4'b0001;
            MUX_HALF:   return 4'b0011;
            MUX_THIRD:  return 4'b0111;
            default:    return 4'b1111;
        endcase
    endfunction

endpackage

// File: rtl/lcd_timebase.sv
// Module: phase timebase. Counts source clocks within a phase and the
// common index within a frame; latches mode and prescaler only at frame
// boundaries. Assumes en low acts as a hold-in-reset.
module lcd_timebase
    import lcd_seq_pkg::*;
#(
    parameter int PRE_W    = 4,
    parameter int TICK_DIV = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [1:0]       mode_sel,
    input  logic [PRE_W-1:0] presc_sel,
    output logic [1:0]       mode_q,
    output logic [1:0]       com_idx,
    output logic             phase_vld,
    output logic             frame_start
);
    localparam int MAX_LEN = 4 * (2 ** PRE_W) * TICK_DIV;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    logic [PRE_W-1:0] presc_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] phase_len;
    logic             phase_end;
    logic             frame_end;

    // Phase length from latched mode and prescaler.
    always_comb begin
        phase_len = CNT_W'(phase_mult(mode_q)) * (CNT_W'(presc_q) + CNT_W'(1))
                  * CNT_W'(TICK_DIV);
        phase_end = (cnt == phase_len - CNT_W'(1));
        frame_end = phase_end && (com_idx == last_com(mode_q));
    end

    // Advance cycle counter and common index; reload settings per frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt     <= '0;
            com_idx <= '0;
            mode_q  <= mode_sel;
            presc_q <= presc_sel;
        end else if (frame_end) begin
            cnt     <= '0;
            com_idx <= '0;
            mode_q  <= mode_sel;
            presc_q <= presc_sel;
        end else if (phase_end) begin
            cnt     <= '0;
            com_idx <= com_idx + 2'd1;
        end else begin
            cnt     <= cnt + CNT_W'(1);
        end
    end

    // Strobes at the first cycle of each phase / frame.
    always_comb begin
        phase_vld   = en && (cnt == '0);
        frame_start = phase_vld && (com_idx == 2'd0);
    end

    AST_IDX_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> com_idx <= last_com(mode_q)) else $error("idx range"); // R2
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> cnt < phase_len) else $error("cnt bound"); // R3
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !frame_end) |=> (mode_q == $past(mode_q))) else $error("mode hold"); // R9
    AST_PRESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !frame_end) |=> (presc_q == $past(presc_q))) else $error("presc hold"); // R9

endmodule

// File: rtl/lcd_pix_store.sv
// Module: pixel store, one row per common, one bit per segment.
// Host row port writes/reads any row; display port reads active row.
// Assumes single write port, synchronous reset clears all rows.
module lcd_pix_store
    import lcd_seq_pkg::*;
#(
    parameter int NUM_SEG = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_we,
    input  logic [1:0]         pix_wcom,
    input  logic [NUM_SEG-1:0] pix_wdata,
    input  logic [1:0]         pix_rcom,
    output logic [NUM_SEG-1:0] pix_rdata,
    input  logic [1:0]         disp_com,
    output logic [NUM_SEG-1:0] disp_row
);
    logic [NUM_SEG-1:0] rows [NUM_COM];

    for (genvar r = 0; r < NUM_COM; r++) begin : g_row
        // Row r register: cleared on reset, loaded on matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rows[r] <= '0;
            end else if (pix_we && (pix_wcom == 2'(r))) begin
                rows[r] <= pix_wdata;
            end
        end
    end

    // Read multiplexers for host and display.
    always_comb begin
        pix_rdata = rows[pix_rcom];
        disp_row  = rows[disp_com];
    end

endmodule

// File: rtl/lcd_pin_ctrl.sv
// Module: pin function control. Holds the segment enable register and
// produces direction overrides for segment and common pins.
// Assumes reset puts every pin back to normal I/O.
module lcd_pin_ctrl
    import lcd_seq_pkg::*;
#(
    parameter int NUM_SEG = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               seg_en_we,
    input  logic [NUM_SEG-1:0] seg_en_wdata,
    input  logic [NUM_COM-1:0] com_used,
    output logic [NUM_SEG-1:0] seg_en_q,
    output logic [NUM_COM-1:0] com_dir_ovr
);
    // Segment enable register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_en_q <= '0;
        end else if (seg_en_we) begin
            seg_en_q <= seg_en_wdata;
        end
    end

    // Commons in use take over their pins.
    always_comb com_dir_ovr = com_used;

    AST_SEG_EN_RESET: assert property (@(posedge clk)
        !rst_n |=> seg_en_q == '0) else $error("seg_en reset"); // R7

endmodule

// File: rtl/lcd_frame_seq.sv
// Module: LCD multiplexed frame sequencer top. Ties the timebase, pixel
// store and pin control together and gates outputs with the enable.
// Assumes a single clock domain driven by the slow source clock.
module lcd_frame_seq
    import lcd_seq_pkg::*;
#(
    parameter int NUM_SEG  = 8,
    parameter int PRE_W    = 4,
    parameter int TICK_DIV = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [1:0]         mode_sel,
    input  logic [PRE_W-1:0]   presc_sel,
    input  logic               pix_we,
    input  logic [1:0]         pix_wcom,
    input  logic [NUM_SEG-1:0] pix_wdata,
    input  logic [1:0]         pix_rcom,
    output logic [NUM_SEG-1:0] pix_rdata,
    input  logic               seg_en_we,
    input  logic [NUM_SEG-1:0] seg_en_wdata,
    output logic [3:0]         com_act,
    output logic [3:0]         com_used,
    output logic [3:0]         com_dir_ovr,
    output logic [NUM_SEG-1:0] seg_row,
    output logic [NUM_SEG-1:0] seg_drv_en,
    output logic               phase_vld,
    output logic               frame_start
);
    logic [1:0]         mode_q;
    logic [1:0]         com_idx;
    logic [NUM_SEG-1:0] disp_row;
    logic [NUM_SEG-1:0] seg_en_q;

    lcd_timebase #(.PRE_W(PRE_W), .TICK_DIV(TICK_DIV)) u_tb (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .mode_sel    (mode_sel),
        .presc_sel   (presc_sel),
        .mode_q      (mode_q),
        .com_idx     (com_idx),
        .phase_vld   (phase_vld),
        .frame_start (frame_start)
    );

    lcd_pix_store #(.NUM_SEG(NUM_SEG)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_we    (pix_we),
        .pix_wcom  (pix_wcom),
        .pix_wdata (pix_wdata),
        .pix_rcom  (pix_rcom),
        .pix_rdata (pix_rdata),
        .disp_com  (com_idx),
        .disp_row  (disp_row)
    );

    lcd_pin_ctrl #(.NUM_SEG(NUM_SEG)) u_pins (
        .clk          (clk),
        .rst_n        (rst_n),
        .seg_en_we    (seg_en_we),
        .seg_en_wdata (seg_en_wdata),
        .com_used     (com_used),
        .seg_en_q     (seg_en_q),
        .com_dir_ovr  (com_dir_ovr)
    );

    // Output gating: commons and segments quiet while disabled.
    always_comb begin
        com_act    = en ? (4'b0001 << com_idx) : 4'b0000;
        com_used   = en ? used_mask(mode_q) : 4'b0000;
        seg_row    = en ? (disp_row & seg_en_q) : '0;
        seg_drv_en = seg_en_q;
    end

    AST_COM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> $onehot(com_act)) else $error("onehot"); // R2
    AST_COM_IN_USED: assert property (@(posedge clk) disable iff (!rst_n)
        (com_act & ~com_dir_ovr) == 4'b0000) else $error("unused com"); // R1
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (com_act == 4'b0000 && seg_row == '0 && !phase_vld)) else $error("quiet"); // R10
    AST_FS_WITH_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> (phase_vld && com_act == 4'b0001)) else $error("fs"); // R4
    AST_SEG_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_row & ~seg_drv_en) == '0) else $error("seg mask"); // R5

endmodule

// File: tb/lcd_frame_seq_test.sv
module lcd_frame_seq_test;
    localparam int NS = 8;
    localparam int TD = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic [1:0]    mode_sel = 2'd0;
    logic [3:0]    presc_sel = 4'd0;
    logic          pix_we = 1'b0;
    logic [1:0]    pix_wcom = 2'd0;
    logic [NS-1:0] pix_wdata = '0;
    logic [1:0]    pix_rcom = 2'd0;
    logic [NS-1:0] pix_rdata;
    logic          seg_en_we = 1'b0;
    logic [NS-1:0] seg_en_wdata = '0;
    logic [3:0]    com_act, com_used, com_dir_ovr;
    logic [NS-1:0] seg_row, seg_drv_en;
    logic          phase_vld, frame_start;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    lcd_frame_seq #(.NUM_SEG(NS), .PRE_W(4), .TICK_DIV(TD)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .mode_sel(mode_sel), .presc_sel(presc_sel),
        .pix_we(pix_we), .pix_wcom(pix_wcom), .pix_wdata(pix_wdata),
        .pix_rcom(pix_rcom), .pix_rdata(pix_rdata),
        .seg_en_we(seg_en_we), .seg_en_wdata(seg_en_wdata),
        .com_act(com_act), .com_used(com_used), .com_dir_ovr(com_dir_ovr),
        .seg_row(seg_row), .seg_drv_en(seg_drv_en),
        .phase_vld(phase_vld), .frame_start(frame_start)
    );

    always #5 clk = ~clk;

    // Vector: mode(2) presc(4) frame_len(8) ncom(3) used(4)
    localparam logic [20:0] VEC [8] = '{
        {2'd0, 4'd0,  8'd8,   3'd1, 4'b0001},
        {2'd1, 4'd0,  8'd8,   3'd2, 4'b0011},
        {2'd2, 4'd0,  8'd6,   3'd3, 4'b0111},
        {2'd3, 4'd0,  8'd8,   3'd4, 4'b1111},
        {2'd0, 4'd3,  8'd32,  3'd1, 4'b0001},
        {2'd1, 4'd2,  8'd24,  3'd2, 4'b0011},
        {2'd2, 4'd15, 8'd96,  3'd3, 4'b0111},
        {2'd3, 4'd15, 8'd128, 3'd4, 4'b1111}
    };

    logic [NS-1:0] rowpat [4];
    localparam logic [NS-1:0] SEGMASK = 8'h7E;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic setup(input logic [1:0] m, input logic [3:0] p);
        en = 1'b0;
        mode_sel = m;
        presc_sel = p;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Enable and measure one full frame, sampling just after each negedge.
    task automatic measure(input int flen, input int ncom, input logic [3:0] used);
        int first = -1;
        int last = -1;
        int nv = 0;
        int plen = flen / ncom;
        en = 1'b1;
        for (int c = 0; c < 400; c++) begin
            #1;
            if (c == 0) begin
                chk("R10 start fs", 32'(frame_start), 32'd1);
                chk("R1 used", 32'(com_used), 32'(used));
                chk("R8 com dir", 32'(com_dir_ovr), 32'(used));
            end
            if (frame_start) begin
                if (first >= 0) begin
                    chk("R3 frame len", 32'(c - first), 32'(flen));
                    break;
                end
                first = c;
            end
            if (phase_vld && first >= 0) begin
                chk("R2 com seq", 32'(com_act), 32'(4'b0001 << nv));
                chk("R5 seg row", 32'(seg_row), 32'(rowpat[nv] & SEGMASK));
                if (nv > 0) chk("R3 phase len", 32'(c - last), 32'(plen));
                last = c;
                nv++;
            end
            @(negedge clk);
        end
        chk("R2 phase count", 32'(nv), 32'(ncom));
        en = 1'b0;
        @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            summary();
        end
    end

    initial begin
        rowpat[0] = 8'hA5; rowpat[1] = 8'h3C; rowpat[2] = 8'hF0; rowpat[3] = 8'h0F;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // Reset state
        chk("R7 seg en reset", 32'(seg_drv_en), 32'd0);
        chk("R10 com off", 32'(com_act), 32'd0);
        chk("R6 row reset", 32'(pix_rdata), 32'd0);
        @(negedge clk);

        // Load rows and segment enables
        for (int r = 0; r < 4; r++) begin
            pix_we = 1'b1; pix_wcom = 2'(r); pix_wdata = rowpat[r];
            @(negedge clk);
        end
        pix_we = 1'b0;
        seg_en_we = 1'b1; seg_en_wdata = SEGMASK;
        @(negedge clk);
        seg_en_we = 1'b0;
        chk("R7 seg drv en", 32'(seg_drv_en), 32'(SEGMASK));

        // Vector table
        for (int v = 0; v < 8; v++) begin
            setup(VEC[v][20:19], VEC[v][18:15]);
            measure(int'(VEC[v][14:7]), int'(VEC[v][6:4]), VEC[v][3:0]);
        end

        // R6: unused rows stay storage in static mode
        setup(2'd0, 4'd0);
        en = 1'b1;
        pix_we = 1'b1; pix_wcom = 2'd3; pix_wdata = 8'h5A;
        @(negedge clk);
        pix_we = 1'b0; pix_rcom = 2'd3;
        #1 chk("R6 unused row rd", 32'(pix_rdata), 32'h5A);
        pix_rcom = 2'd2;
        #1 chk("R6 row2 rd", 32'(pix_rdata), 32'(rowpat[2]));
        rowpat[3] = 8'h5A;
        en = 1'b0;
        @(negedge clk);

        // R10: disable mid-frame, then restart
        setup(2'd3, 4'd0);
        en = 1'b1;
        repeat (3) @(negedge clk);
        en = 1'b0;
        #1;
        chk("R10 off com", 32'(com_act), 32'd0);
        chk("R10 off seg", 32'(seg_row), 32'd0);
        chk("R10 off used", 32'(com_used), 32'd0);
        chk("R10 off vld", 32'({phase_vld, frame_start}), 32'd0);
        @(negedge clk);
        @(negedge clk);
        en = 1'b1;
        #1;
        chk("R10 restart fs", 32'(frame_start), 32'd1);
        chk("R10 restart com", 32'(com_act), 32'd1);
        en = 1'b0;
        @(negedge clk);

        // R9: change mode and prescaler during phase 1 of a 1/4 frame
        setup(2'd3, 4'd0);
        en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        #1 chk("R9 in phase1", 32'(com_act), 32'b0010);
        mode_sel = 2'd0; presc_sel = 4'd1;
        #1 chk("R9 used held", 32'(com_used), 32'b1111);
        begin
            int seen = 0;
            int fs_at = -1;
            logic [3:0] expseq [3] = '{4'b0100, 4'b1000, 4'b0001};
            for (int c = 0; c < 200; c++) begin
                @(negedge clk);
                #1;
                if (phase_vld && seen < 3) begin
                    chk("R9 seq", 32'(com_act), 32'(expseq[seen]));
                    if (seen < 2) chk("R9 old len used", 32'(com_used), 32'b1111);
                    seen++;
                end
                if (frame_start) begin
                    if (fs_at >= 0) begin
                        chk("R9 new frame len", 32'(c - fs_at), 32'd16);
                        break;
                    end
                    fs_at = c;
                    chk("R9 new used", 32'(com_used), 32'b0001);
                end
            end
        end
        en = 1'b0;
        @(negedge clk);

        // R4: frame_start lasts one cycle
        setup(2'd2, 4'd0);
        en = 1'b1;
        #1 chk("R4 fs high", 32'(frame_start), 32'd1);
        @(negedge clk);
        #1 chk("R4 fs one cycle", 32'({frame_start, phase_vld}), 32'd0);
        en = 1'b0;
        @(negedge clk);

        done = 1'b1;
        summary();
    end

endmodule